// File: doc/BRIEF.md
# TDM Channel Bit-Error-Rate Tester

This block tests one TDM port for bit errors with a pseudo-random test pattern. The port's timeslot scheduler presents one slot per clock. Each slot carries a valid flag, a stream number and a channel number. The transmit half replaces the data of selected output slots with a pseudo-random byte sequence. The selection is one stream and a run of consecutive channels, repeated in every frame. The receive half watches a matching window of input slots. It first waits for the sequence's opening byte and then locks. From lock onward it checks every window byte against a locally generated copy of the sequence and adds up the wrong bits in a saturating 16-bit counter.

Each half is armed when its start input goes from low to high. A rising edge reloads the generator from the seed. On the receive half it also clears both the lock and the count. While its start input is held high, a half keeps running. Lowering the start input halts it, and the error count stays readable. The stream, first-channel and channel-count settings are read live, so they should be held steady while a test runs. The channel number used by the receive window is the one presented on the slot inputs, before any per-stream input delay is applied.

Top module: `tdm_ber_tester`

## Requirements
- R1: After reset, tx_ins and rx_lock are 0 and err_cnt is 0.
- R2: tx_ins is 1 exactly in a slot where all of the following hold: tx_slot_vld is high, tx_slot_strm equals tx_strm_sel, and tx_slot_ch lies in [tx_ch_first, tx_ch_first + N - 1]. N is tx_ch_count, or 1 when tx_ch_count is 0. The window never wraps past the highest channel number. The transmitter must also be running, and tx_byte is 0 in every slot where tx_ins is 0.
- R3: The sequence comes from a 15-bit register s. One step shifts s left and puts s[14] XOR s[13] into s[0], which is the polynomial x^15 + x^14 + 1. The byte sent in an inserted slot is s[14:7], and s then advances 8 steps. Slots outside the window leave s alone, so the sequence carries on across frames. The first byte after a start is SEED[14:7].
- R4: A rising edge on tx_start reloads s with SEED and starts the transmitter in the following cycle. Whenever tx_start is low, nothing is inserted.
- R5: While the receiver runs unlocked, a receive window slot whose rx_byte equals SEED[14:7] sets rx_lock. rx_lock rises one clock after that slot, and no error is counted for that byte.
- R6: After lock, every receive window slot is compared with the next byte of a local copy of the sequence. The copy starts from SEED advanced 8 steps. The number of differing bits is added to err_cnt, which shows the sum one clock later.
- R7: err_cnt saturates at 0xFFFF and stays there.
- R8: A rising edge on rx_start clears rx_lock and err_cnt one clock later and restarts the search. A low rx_start clears rx_lock and holds err_cnt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_start | input | 1 | Transmitter start; rising edge arms, high keeps running |
| tx_strm_sel | input | STRW | Output stream carrying the test pattern |
| tx_ch_first | input | CHW | First channel of the transmit window |
| tx_ch_count | input | CHW+1 | Transmit window length in channels (0 acts as 1) |
| tx_slot_vld | input | 1 | Current output slot is valid |
| tx_slot_strm | input | STRW | Stream of the current output slot |
| tx_slot_ch | input | CHW | Channel of the current output slot |
| tx_ins | output | 1 | Current output slot is replaced by the pattern |
| tx_byte | output | 8 | Pattern byte for the current slot |
| rx_start | input | 1 | Receiver start; rising edge arms, high keeps running |
| rx_strm_sel | input | STRW | Input stream to check |
| rx_ch_first | input | CHW | First channel of the receive window |
| rx_ch_count | input | CHW+1 | Receive window length in channels (0 acts as 1) |
| rx_slot_vld | input | 1 | Current input slot is valid |
| rx_slot_strm | input | STRW | Stream of the current input slot |
| rx_slot_ch | input | CHW | Channel of the current input slot, undelayed |
| rx_byte | input | 8 | Received data of the current input slot |
| rx_lock | output | 1 | Receiver has found the seed byte and is checking |
| err_cnt | output | 16 | Saturating count of mismatched bits |

## Verification
Saturation of the error counter is the hardest condition to reach, because it needs more than 65,535 bad bits and the receiver must be locked before any of them count. The bench loops the transmitter back into the receiver with a one-stream, full-frame window, so every slot is a test slot. It leaves the data untouched until rx_lock rises and then inverts every byte, so each slot adds 8 errors. About 8,200 slots bring the counter to its ceiling, after which further frames must leave it there. Restarting the receiver while the transmitter is mid-sequence, and a window that runs past the last channel, are also driven on purpose.

// File: rtl/tdm_ber_tester.sv
module tdm_ber_tester #(
  parameter int STRW = 4,
  parameter int CHW = 5,
  parameter logic [14:0] SEED = 15'h5A3C
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_start,
  input  logic [STRW-1:0] tx_strm_sel,
  input  logic [CHW-1:0]  tx_ch_first,
  input  logic [CHW:0]    tx_ch_count,
  input  logic            tx_slot_vld,
  input  logic [STRW-1:0] tx_slot_strm,
  input  logic [CHW-1:0]  tx_slot_ch,
  output logic            tx_ins,
  output logic [7:0]      tx_byte,
  input  logic            rx_start,
  input  logic [STRW-1:0] rx_strm_sel,
  input  logic [CHW-1:0]  rx_ch_first,
  input  logic [CHW:0]    rx_ch_count,
  input  logic            rx_slot_vld,
  input  logic [STRW-1:0] rx_slot_strm,
  input  logic [CHW-1:0]  rx_slot_ch,
  input  logic [7:0]      rx_byte,
  output logic            rx_lock,
  output logic [15:0]     err_cnt
);

  function automatic logic [14:0] adv8(input logic [14:0] s);
    logic [14:0] t;
    t = s;
    for (int i = 0; i < 8; i++) t = {t[13:0], t[14] ^ t[13]};
    return t;
  endfunction

  function automatic logic [3:0] ones8(input logic [7:0] v);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < 8; i++) n = n + {3'b000, v[i]};
    return n;
  endfunction

  function automatic logic in_win(input logic [CHW-1:0] ch, input logic [CHW-1:0] first,
                                  input logic [CHW:0] cnt);
    logic [CHW:0] d, n;
    d = {1'b0, ch} - {1'b0, first};
    n = (cnt == '0) ? {{CHW{1'b0}}, 1'b1} : cnt;
    return (ch >= first) && (d < n);
  endfunction

  logic        tx_start_q, rx_start_q, tx_run, rx_run;
  logic [14:0] tx_st, rx_ref;
  logic        tx_rise, rx_rise, rx_hit;
  logic [7:0]  rx_diff;
  logic [16:0] cnt_sum;
  logic [15:0] cnt_next;

  assign tx_rise = tx_start & ~tx_start_q;
  assign rx_rise = rx_start & ~rx_start_q;

  assign tx_ins = tx_run & tx_start & tx_slot_vld & (tx_slot_strm == tx_strm_sel)
                & in_win(tx_slot_ch, tx_ch_first, tx_ch_count);
  assign tx_byte = tx_ins ? tx_st[14:7] : 8'h00;

  assign rx_hit = rx_run & rx_start & rx_slot_vld & (rx_slot_strm == rx_strm_sel)
                & in_win(rx_slot_ch, rx_ch_first, rx_ch_count);
  assign rx_diff  = rx_byte ^ rx_ref[14:7];
  assign cnt_sum  = {1'b0, err_cnt} + {13'd0, ones8(rx_diff)};
  assign cnt_next = cnt_sum[16] ? 16'hFFFF : cnt_sum[15:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_start_q <= 1'b0;
      tx_run     <= 1'b0;
      tx_st      <= SEED;
    end else begin
      tx_start_q <= tx_start;
      if (tx_rise) begin
        tx_run <= 1'b1;
        tx_st  <= SEED;
      end else if (!tx_start) begin
        tx_run <= 1'b0;
      end else if (tx_ins) begin
        tx_st <= adv8(tx_st);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_start_q <= 1'b0;
      rx_run     <= 1'b0;
      rx_lock    <= 1'b0;
      rx_ref     <= SEED;
      err_cnt    <= '0;
    end else begin
      rx_start_q <= rx_start;
      if (rx_rise) begin
        rx_run  <= 1'b1;
        rx_lock <= 1'b0;
        err_cnt <= '0;
        rx_ref  <= adv8(SEED);
      end else if (!rx_start) begin
        rx_run  <= 1'b0;
        rx_lock <= 1'b0;
      end else if (rx_hit) begin
        if (!rx_lock) begin
          if (rx_byte == SEED[14:7]) rx_lock <= 1'b1;
        end else begin
          err_cnt <= cnt_next;
          rx_ref  <= adv8(rx_ref);
        end
      end
    end
  end

  // R4
  tx_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_start |-> !tx_ins);

  // R5
  lock_needs_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_lock && !rx_hit) |=> !rx_lock);

  // R6
  no_count_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_lock && !rx_rise) |=> $stable(err_cnt));

  // R7
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt == 16'hFFFF && !rx_rise) |=> err_cnt == 16'hFFFF);

  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_rise |=> err_cnt >= $past(err_cnt));

  // R8
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rise |=> (err_cnt == 16'd0 && !rx_lock));

endmodule

// File: tb/sim_tdm_ber_tester.sv
module sim_tdm_ber_tester;
  localparam int STRW = 4;
  localparam int CHW = 5;
  localparam logic [14:0] SEED = 15'h5A3C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic            tx_start = 0, rx_start = 0, tx_slot_vld = 0;
  logic [STRW-1:0] tx_strm_sel = 0, rx_strm_sel = 0, tx_slot_strm = 0;
  logic [CHW-1:0]  tx_ch_first = 0, rx_ch_first = 0, tx_slot_ch = 0;
  logic [CHW:0]    tx_ch_count = 1, rx_ch_count = 1;
  logic [7:0]      flip = 0;
  logic            tx_ins, rx_lock;
  logic [7:0]      tx_byte, rx_byte;
  logic [15:0]     err_cnt;

  assign rx_byte = tx_byte ^ flip;

  tdm_ber_tester #(.STRW(STRW), .CHW(CHW), .SEED(SEED)) u0 (
    .clk(clk), .rst_n(rst_n),
    .tx_start(tx_start), .tx_strm_sel(tx_strm_sel), .tx_ch_first(tx_ch_first),
    .tx_ch_count(tx_ch_count), .tx_slot_vld(tx_slot_vld), .tx_slot_strm(tx_slot_strm),
    .tx_slot_ch(tx_slot_ch), .tx_ins(tx_ins), .tx_byte(tx_byte),
    .rx_start(rx_start), .rx_strm_sel(rx_strm_sel), .rx_ch_first(rx_ch_first),
    .rx_ch_count(rx_ch_count), .rx_slot_vld(tx_slot_vld), .rx_slot_strm(tx_slot_strm),
    .rx_slot_ch(tx_slot_ch), .rx_byte(rx_byte), .rx_lock(rx_lock), .err_cnt(err_cnt));

  int compared = 0, mismatched = 0, ins_seen = 0;
  int m_ts, m_rs, m_cnt;
  bit m_trun, m_rrun, m_lock, m_tq, m_rq, done = 0;
  int first_byte = -1;
  int flip_mode = 0;

  function automatic int lfsr8(int s);
    int v = s;
    for (int k = 0; k < 8; k++) v = ((v << 1) | (((v >> 14) ^ (v >> 13)) & 1)) & 32'h7FFF;
    return v;
  endfunction

  function automatic bit inside_win(int ch, int first, int cnt);
    int n = (cnt == 0) ? 1 : cnt;
    return (ch >= first) && (ch < first + n);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      m_ts = SEED; m_rs = SEED; m_cnt = 0;
      m_trun = 0; m_rrun = 0; m_lock = 0; m_tq = 0; m_rq = 0;
    end else begin
      bit e_ins, hit;
      int e_byte, d;
      e_ins = m_trun && tx_start && tx_slot_vld && (tx_slot_strm == tx_strm_sel)
              && inside_win(tx_slot_ch, tx_ch_first, tx_ch_count);
      e_byte = e_ins ? ((m_ts >> 7) & 255) : 0;
      check(tx_ins == e_ins, "R2 tx_ins", tx_ins, e_ins);
      check(tx_byte == e_byte, "R3 tx_byte", tx_byte, e_byte);
      check(rx_lock == m_lock, "R5 rx_lock", rx_lock, m_lock);
      check(err_cnt == m_cnt, "R6 err_cnt", err_cnt, m_cnt);
      if (tx_ins) begin
        ins_seen++;
        if (first_byte < 0) first_byte = tx_byte;
      end
      hit = m_rrun && rx_start && tx_slot_vld && (tx_slot_strm == rx_strm_sel)
            && inside_win(tx_slot_ch, rx_ch_first, rx_ch_count);
      if (tx_start && !m_tq) begin m_trun = 1; m_ts = SEED; end
      else if (!tx_start) m_trun = 0;
      else if (e_ins) m_ts = lfsr8(m_ts);
      if (rx_start && !m_rq) begin m_rrun = 1; m_lock = 0; m_cnt = 0; m_rs = lfsr8(SEED); end
      else if (!rx_start) begin m_rrun = 0; m_lock = 0; end
      else if (hit) begin
        if (!m_lock) begin
          if (rx_byte == SEED[14:7]) m_lock = 1;
        end else begin
          d = $countones(rx_byte ^ 8'((m_rs >> 7) & 255));
          m_cnt = (m_cnt + d > 65535) ? 65535 : m_cnt + d;
          m_rs = lfsr8(m_rs);
        end
      end
      m_tq = tx_start; m_rq = rx_start;
    end
  end

  task automatic frames(int nf, int nstr, int nch);
    for (int f = 0; f < nf; f++)
      for (int s = 0; s < nstr; s++)
        for (int c = 0; c < nch; c++) begin
          @(posedge clk); #2;
          tx_slot_vld = 1; tx_slot_strm = STRW'(s); tx_slot_ch = CHW'(c);
          case (flip_mode)
            1: flip = (s == int'(tx_strm_sel) && c == int'(tx_ch_first) + 1) ? 8'h05 : 8'h00;
            2: flip = rx_lock ? 8'hFF : 8'h00;
            default: flip = 8'h00;
          endcase
        end
    @(posedge clk); #2; tx_slot_vld = 0; flip = 0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    idle(2);
    @(posedge clk); #2; rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(tx_ins == 0 && rx_lock == 0 && err_cnt == 0, "R1", {tx_ins, rx_lock, err_cnt}, 0);
    idle(2);

    // Receiver armed before transmitter: no lock from idle data (R5)
    tx_strm_sel = 2; tx_ch_first = 3; tx_ch_count = 4;
    rx_strm_sel = 2; rx_ch_first = 3; rx_ch_count = 4;
    rx_start = 1; frames(1, 4, 16);
    check(rx_lock == 0, "R5 no lock before seed", rx_lock, 0);
    // R4 transmitter starts, R3 first byte is seed byte
    @(posedge clk); #2; rx_start = 0; tx_start = 1; idle(1); rx_start = 1;
    ins_seen = 0; first_byte = -1;
    frames(3, 4, 16);
    check(first_byte == int'(SEED[14:7]), "R3 first byte", first_byte, SEED[14:7]);
    check(ins_seen == 12, "R2 window count", ins_seen, 12);
    check(rx_lock == 1, "R5 locked", rx_lock, 1);
    check(err_cnt == 0, "R6 clean loop", err_cnt, 0);

    // R6 two flipped bits per frame
    flip_mode = 1; frames(3, 4, 16); flip_mode = 0;
    check(err_cnt == 6, "R6 injected errors", err_cnt, 6);

    // R8 stop holds count, restart clears
    @(posedge clk); #2; rx_start = 0; idle(2);
    check(rx_lock == 0 && err_cnt == 6, "R8 stop holds", err_cnt, 6);
    @(posedge clk); #2; rx_start = 1; idle(1);
    @(negedge clk);
    check(rx_lock == 0 && err_cnt == 0, "R8 restart clears", err_cnt, 0);
    // restart both ends together to relock
    @(posedge clk); #2; tx_start = 0; rx_start = 0; idle(1);
    tx_start = 1; rx_start = 1; frames(2, 4, 16);
    check(rx_lock == 1 && err_cnt == 0, "R8 relock", err_cnt, 0);

    // R2 zero length acts as one; window at frame end truncates
    tx_ch_count = 0; ins_seen = 0; frames(2, 4, 16);
    check(ins_seen == 2, "R2 zero length", ins_seen, 2);
    tx_ch_first = 14; tx_ch_count = 5; ins_seen = 0; frames(2, 4, 16);
    check(ins_seen == 4, "R2 window end", ins_seen, 4);

    // R4 transmitter stopped
    tx_start = 0; ins_seen = 0; frames(2, 4, 16);
    check(ins_seen == 0, "R4 stopped", ins_seen, 0);

    // R7 saturation with full-frame single stream window
    @(posedge clk); #2; rx_start = 0;
    tx_strm_sel = 0; rx_strm_sel = 0; tx_ch_first = 0; rx_ch_first = 0;
    tx_ch_count = 16; rx_ch_count = 16; idle(1);
    tx_start = 1; rx_start = 1;
    flip_mode = 2; frames(520, 1, 16);
    check(err_cnt == 16'hFFFF, "R7 saturated", err_cnt, 16'hFFFF);
    frames(4, 1, 16); flip_mode = 0;
    check(err_cnt == 16'hFFFF, "R7 held", err_cnt, 16'hFFFF);

    idle(3);
    finish_run();
  end
endmodule